// File: doc/BRIEF.md
# DES Round Execution Unit

This unit sits beside a processor core and runs the DES cipher one round at a time under firmware control. It holds two 28-bit key-half registers and one 64-bit block register. Four operations act on them: a key load, a block load, a block read and a single Feistel round. Firmware loads a key and a block, issues sixteen round operations with round indices 0 to 15, and reads the result back as two 32-bit words. Every operation takes effect at one clock edge and is acknowledged by a one-cycle `done` pulse.

The block register holds the data after the initial permutation, so a load applies that permutation. A read undoes the last round's half swap and applies the inverse permutation, so the value read after sixteen rounds is the finished ciphertext or plaintext. The key operand is already reduced to 56 bits by the first key permutation. Each round derives its 48-bit subkey from the rotated halves. The rotation direction and timing depend on the decrypt flag, and the halves return to their loaded value after a full pass in either direction.

Top module: `desrc_unit`

## Requirements
- R1: After a synchronous reset, `done` is 0, `rd_word` is 0, and the block and key registers hold zero, so a read returns 0 in both words.
- R2: Each cycle with `op_valid` high makes `done` high in the following cycle only, and a read's word appears on `rd_word` in that same cycle.
- R3: With `op_valid` low, no register changes, `done` stays 0 and `rd_word` holds its value, whatever the other inputs carry.
- R4: Operation code 00 (key load) puts `op_data[55:28]` into the left key half and `op_data[27:0]` into the right key half; no other operation except a round alters them.
- R5: Operation code 01 (block load) stores the initial permutation of `op_data`. Operation code 10 (read) returns the inverse permutation of the block with its halves swapped: bits 63:32 when `op_hi` is 1, bits 31:0 when it is 0. Bit 63 is the first cipher bit.
- R6: Operation code 11 (round) with `op_decrypt` 0, issued for indices 0..15 in order after loading key and plaintext, leaves a block whose read gives the standard DES ciphertext. Each round moves the right half into the left half.
- R7: In encrypt rounds the key halves rotate left by 1 at indices 0, 1, 8 and 15 and by 2 at the others, before the subkey is taken by the second key permutation.
- R8: In decrypt rounds the subkey is taken from the halves as they stand. The halves then rotate right by the encrypt amount of index 15 minus the round index. Sixteen such rounds on a ciphertext recover the plaintext.
- R9: After sixteen rounds in either direction the key halves equal their loaded value, so encrypt and decrypt passes may follow each other without reloading the key.
- R10: A read leaves the block register unchanged; two reads in a row return the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation issue strobe |
| op_kind | input | 2 | 00 key load, 01 block load, 10 read, 11 round |
| op_data | input | 64 | Key (low 56 bits) or block operand |
| op_round | input | 4 | Round index 0..15 for a round |
| op_decrypt | input | 1 | Round direction: 1 selects decryption |
| op_hi | input | 1 | Read word select: 1 upper, 0 lower |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 32 | Word returned by the latest read |

## Verification
The cipher widths are fixed by the algorithm, so the bench builds the unit with the package's single set of sizes. It drives full sixteen-round passes with known-answer key, plaintext and ciphertext triples. These include an all-zero key and block and a patterned key, so every S-box, permutation and rotation amount feeds the compared result. Decrypt passes run straight after encrypt passes without a key reload, which shows that the rotation schedule closes on itself in both directions. Idle cycles with live-looking inputs confirm that nothing moves without the strobe.

// File: rtl/desrc_pkg.sv
package desrc_pkg;

    localparam int BLK_W  = 64;
    localparam int HALF_W = BLK_W / 2;
    localparam int KEYH_W = 28;
    localparam int KEY_W  = 2 * KEYH_W;
    localparam int SUB_W  = 48;
    localparam int RND_W  = 4;

    typedef enum logic [1:0] {
        OP_KEY   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_READ  = 2'b10,
        OP_ROUND = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic [HALF_W-1:0] l;
        logic [HALF_W-1:0] r;
    } block_t;

    localparam int unsigned IP_T [64] = '{
        58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
        62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
        57, 49, 41, 33, 25, 17, 9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
        61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};

    localparam int unsigned FP_T [64] = '{
        40, 8, 48, 16, 56, 24, 64, 32, 39, 7, 47, 15, 55, 23, 63, 31,
        38, 6, 46, 14, 54, 22, 62, 30, 37, 5, 45, 13, 53, 21, 61, 29,
        36, 4, 44, 12, 52, 20, 60, 28, 35, 3, 43, 11, 51, 19, 59, 27,
        34, 2, 42, 10, 50, 18, 58, 26, 33, 1, 41, 9, 49, 17, 57, 25};

    localparam int unsigned E_T [48] = '{
        32, 1, 2, 3, 4, 5, 4, 5, 6, 7, 8, 9, 8, 9, 10, 11, 12, 13,
        12, 13, 14, 15, 16, 17, 16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
        24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32, 1};

    localparam int unsigned P_T [32] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

    localparam int unsigned PC2_T [48] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10, 23, 19, 12, 4,
        26, 8, 16, 7, 27, 20, 13, 2, 41, 52, 31, 37, 47, 55, 30, 40,
        51, 45, 33, 48, 44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    localparam logic [3:0] SB0 [64] = '{
        14, 4, 13, 1, 2, 15, 11, 8, 3, 10, 6, 12, 5, 9, 0, 7,
        0, 15, 7, 4, 14, 2, 13, 1, 10, 6, 12, 11, 9, 5, 3, 8,
        4, 1, 14, 8, 13, 6, 2, 11, 15, 12, 9, 7, 3, 10, 5, 0,
        15, 12, 8, 2, 4, 9, 1, 7, 5, 11, 3, 14, 10, 0, 6, 13};
    localparam logic [3:0] SB1 [64] = '{
        15, 1, 8, 14, 6, 11, 3, 4, 9, 7, 2, 13, 12, 0, 5, 10,
        3, 13, 4, 7, 15, 2, 8, 14, 12, 0, 1, 10, 6, 9, 11, 5,
        0, 14, 7, 11, 10, 4, 13, 1, 5, 8, 12, 6, 9, 3, 2, 15,
        13, 8, 10, 1, 3, 15, 4, 2, 11, 6, 7, 12, 0, 5, 14, 9};
    localparam logic [3:0] SB2 [64] = '{
        10, 0, 9, 14, 6, 3, 15, 5, 1, 13, 12, 7, 11, 4, 2, 8,
        13, 7, 0, 9, 3, 4, 6, 10, 2, 8, 5, 14, 12, 11, 15, 1,
        13, 6, 4, 9, 8, 15, 3, 0, 11, 1, 2, 12, 5, 10, 14, 7,
        1, 10, 13, 0, 6, 9, 8, 7, 4, 15, 14, 3, 11, 5, 2, 12};
    localparam logic [3:0] SB3 [64] = '{
        7, 13, 14, 3, 0, 6, 9, 10, 1, 2, 8, 5, 11, 12, 4, 15,
        13, 8, 11, 5, 6, 15, 0, 3, 4, 7, 2, 12, 1, 10, 14, 9,
        10, 6, 9, 0, 12, 11, 7, 13, 15, 1, 3, 14, 5, 2, 8, 4,
        3, 15, 0, 6, 10, 1, 13, 8, 9, 4, 5, 11, 12, 7, 2, 14};
    localparam logic [3:0] SB4 [64] = '{
        2, 12, 4, 1, 7, 10, 11, 6, 8, 5, 3, 15, 13, 0, 14, 9,
        14, 11, 2, 12, 4, 7, 13, 1, 5, 0, 15, 10, 3, 9, 8, 6,
        4, 2, 1, 11, 10, 13, 7, 8, 15, 9, 12, 5, 6, 3, 0, 14,
        11, 8, 12, 7, 1, 14, 2, 13, 6, 15, 0, 9, 10, 4, 5, 3};
    localparam logic [3:0] SB5 [64] = '{
        12, 1, 10, 15, 9, 2, 6, 8, 0, 13, 3, 4, 14, 7, 5, 11,
        10, 15, 4, 2, 7, 12, 9, 5, 6, 1, 13, 14, 0, 11, 3, 8,
        9, 14, 15, 5, 2, 8, 12, 3, 7, 0, 4, 10, 1, 13, 11, 6,
        4, 3, 2, 12, 9, 5, 15, 10, 11, 14, 1, 7, 6, 0, 8, 13};
    localparam logic [3:0] SB6 [64] = '{
        4, 11, 2, 14, 15, 0, 8, 13, 3, 12, 9, 7, 5, 10, 6, 1,
        13, 0, 11, 7, 4, 9, 1, 10, 14, 3, 5, 12, 2, 15, 8, 6,
        1, 4, 11, 13, 12, 3, 7, 14, 10, 15, 6, 8, 0, 5, 9, 2,
        6, 11, 13, 8, 1, 4, 10, 7, 9, 5, 0, 15, 14, 2, 3, 12};
    localparam logic [3:0] SB7 [64] = '{
        13, 2, 8, 4, 6, 15, 11, 1, 10, 9, 3, 14, 5, 0, 12, 7,
        1, 15, 13, 8, 10, 3, 7, 4, 12, 5, 6, 11, 0, 14, 9, 2,
        7, 11, 4, 1, 9, 12, 14, 2, 0, 6, 10, 13, 15, 3, 5, 8,
        2, 1, 14, 7, 4, 10, 8, 13, 15, 12, 9, 0, 3, 5, 6, 11};

    // Table positions count from 1 at the most significant bit.
    function automatic logic [63:0] perm_ip(input logic [63:0] x);
        logic [63:0] y;
        for (int k = 0; k < 64; k++) y[6'(63 - k)] = x[6'(64 - IP_T[6'(k)])];
        return y;
    endfunction

    function automatic logic [63:0] perm_fp(input logic [63:0] x);
        logic [63:0] y;
        for (int k = 0; k < 64; k++) y[6'(63 - k)] = x[6'(64 - FP_T[6'(k)])];
        return y;
    endfunction

    function automatic logic [47:0] perm_e(input logic [31:0] x);
        logic [47:0] y;
        for (int k = 0; k < 48; k++) y[6'(47 - k)] = x[5'(32 - E_T[6'(k)])];
        return y;
    endfunction

    function automatic logic [31:0] perm_p(input logic [31:0] x);
        logic [31:0] y;
        for (int k = 0; k < 32; k++) y[5'(31 - k)] = x[5'(32 - P_T[5'(k)])];
        return y;
    endfunction

    function automatic logic [47:0] perm_pc2(input logic [55:0] x);
        logic [47:0] y;
        for (int k = 0; k < 48; k++) y[6'(47 - k)] = x[6'(56 - PC2_T[6'(k)])];
        return y;
    endfunction

    function automatic logic [3:0] sbox_lookup(input int unsigned which, input logic [5:0] six);
        logic [5:0] idx;
        idx = {six[5], six[0], six[4:1]};
        case (which)
            0: return SB0[idx];
            1: return SB1[idx];
            2: return SB2[idx];
            3: return SB3[idx];
            4: return SB4[idx];
            5: return SB5[idx];
            6: return SB6[idx];
            7: return SB7[idx];
            default: return 4'h0;
        endcase
    endfunction

    // Encrypt schedule: single step at indices 0, 1, 8, 15, double elsewhere.
    function automatic logic shift_is_two(input logic [RND_W-1:0] rnd);
        return !(rnd == 4'd0 || rnd == 4'd1 || rnd == 4'd8 || rnd == 4'd15);
    endfunction

    function automatic logic [KEYH_W-1:0] rotl28(input logic [KEYH_W-1:0] x, input logic two);
        return two ? {x[KEYH_W-3:0], x[KEYH_W-1:KEYH_W-2]} : {x[KEYH_W-2:0], x[KEYH_W-1]};
    endfunction

    function automatic logic [KEYH_W-1:0] rotr28(input logic [KEYH_W-1:0] x, input logic two);
        return two ? {x[1:0], x[KEYH_W-1:2]} : {x[0], x[KEYH_W-1:1]};
    endfunction

endpackage

// File: rtl/desrc_sbox.sv
module desrc_sbox
    import desrc_pkg::*;
#(
    parameter int unsigned BOX = 0
) (
    input  logic [5:0] six,
    output logic [3:0] four
);
    assign four = sbox_lookup(BOX, six);
endmodule

// File: rtl/desrc_feistel.sv
module desrc_feistel
    import desrc_pkg::*;
(
    input  logic [HALF_W-1:0] r_half,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out
);
    localparam int NBOX = SUB_W / 6;

    logic [SUB_W-1:0]  mixed;
    logic [HALF_W-1:0] s_out;

    assign mixed = perm_e(r_half) ^ subkey;

    for (genvar g = 0; g < NBOX; g++) begin : g_box
        desrc_sbox #(.BOX(g)) u_sb (
            .six  (mixed[SUB_W-1-6*g -: 6]),
            .four (s_out[HALF_W-1-4*g -: 4])
        );
    end

    assign f_out = perm_p(s_out);
endmodule

// File: rtl/desrc_keysched.sv
module desrc_keysched
    import desrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [KEY_W-1:0]  load_val,
    input  logic              step_en,
    input  logic [RND_W-1:0]  step_round,
    input  logic              step_dec,
    output logic [SUB_W-1:0]  subkey,
    output logic [KEY_W-1:0]  key_now
);
    logic [KEYH_W-1:0] c_q, d_q;
    logic [KEYH_W-1:0] c_use, d_use, c_nxt, d_nxt;
    logic              dbl;

    always_comb begin
        // Decrypt round i undoes the encrypt shift of index 15-i.
        dbl = step_dec ? shift_is_two(~step_round) : shift_is_two(step_round);
        if (!step_dec) begin
            c_use = rotl28(c_q, dbl);
            d_use = rotl28(d_q, dbl);
            c_nxt = c_use;
            d_nxt = d_use;
        end else begin
            c_use = c_q;
            d_use = d_q;
            c_nxt = rotr28(c_q, dbl);
            d_nxt = rotr28(d_q, dbl);
        end
        subkey = perm_pc2({c_use, d_use});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
            d_q <= '0;
        end else if (load_en) begin
            c_q <= load_val[KEY_W-1:KEYH_W];
            d_q <= load_val[KEYH_W-1:0];
        end else if (step_en) begin
            c_q <= c_nxt;
            d_q <= d_nxt;
        end
    end

    assign key_now = {c_q, d_q};
endmodule

// File: rtl/desrc_unit.sv
module desrc_unit
    import desrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [BLK_W-1:0]  op_data,
    input  logic [RND_W-1:0]  op_round,
    input  logic              op_decrypt,
    input  logic              op_hi,
    output logic              done,
    output logic [HALF_W-1:0] rd_word
);
    op_kind_e          kind;
    logic              do_key, do_load, do_read, do_round;
    block_t            data_q;
    logic [BLK_W-1:0]  data_now;
    logic [BLK_W-1:0]  out_blk;
    logic [KEY_W-1:0]  key_now;
    logic [SUB_W-1:0]  subkey;
    logic [HALF_W-1:0] f_out;

    assign kind     = op_kind_e'(op_kind);
    assign do_key   = op_valid && (kind == OP_KEY);
    assign do_load  = op_valid && (kind == OP_LOAD);
    assign do_read  = op_valid && (kind == OP_READ);
    assign do_round = op_valid && (kind == OP_ROUND);

    desrc_keysched u_ks (
        .clk        (clk),
        .rst        (rst),
        .load_en    (do_key),
        .load_val   (op_data[KEY_W-1:0]),
        .step_en    (do_round),
        .step_round (op_round),
        .step_dec   (op_decrypt),
        .subkey     (subkey),
        .key_now    (key_now)
    );

    desrc_feistel u_f (
        .r_half (data_q.r),
        .subkey (subkey),
        .f_out  (f_out)
    );

    // The swap of the last round is undone here, then the inverse permutation.
    assign out_blk  = perm_fp({data_q.r, data_q.l});
    assign data_now = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            done    <= 1'b0;
            rd_word <= '0;
        end else begin
            done <= op_valid;
            if (do_load) begin
                data_q <= perm_ip(op_data);
            end else if (do_round) begin
                data_q.l <= data_q.r;
                data_q.r <= data_q.l ^ f_out;
            end
            if (do_read) begin
                rd_word <= op_hi ? out_blk[BLK_W-1:HALF_W] : out_blk[HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/desrc_unit_chk.sv
module desrc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_kind,
    input logic [55:0] key_in,
    input logic        done,
    input logic [31:0] rd_word,
    input logic [55:0] key_now,
    input logic [63:0] data_now
);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> done);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !done);

    p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(rd_word) && $stable(data_now) && $stable(key_now)));

    p_key_write_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b00) |=> (key_now == $past(key_in)));

    p_key_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_kind == 2'b01 || op_kind == 2'b10)) |=> $stable(key_now));

    p_half_move_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b11) |=> (data_now[63:32] == $past(data_now[31:0])));

    p_rot_weight_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b11) |=>
            ($countones(key_now[55:28]) == $past($countones(key_now[55:28])) &&
             $countones(key_now[27:0]) == $past($countones(key_now[27:0]))));

    p_read_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b10) |=> $stable(data_now));
endmodule

bind desrc_unit desrc_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .key_in   (op_data[55:0]),
    .done     (done),
    .rd_word  (rd_word),
    .key_now  (key_now),
    .data_now (data_now)
);

// File: tb/tb_desrc_unit.sv
`timescale 1ns/1ps
module tb_desrc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [63:0] op_data;
    logic [3:0]  op_round;
    logic        op_decrypt;
    logic        op_hi;
    logic        done;
    logic [31:0] rd_word;

    int          n_run  = 0;
    int          n_fail = 0;
    bit          ended  = 0;
    logic        exp_done;
    logic [31:0] exp_word;
    logic [63:0] exp_out;

    localparam int unsigned PC1_T [56] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

    always #2 clk = ~clk;

    desrc_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_data(op_data), .op_round(op_round), .op_decrypt(op_decrypt),
        .op_hi(op_hi), .done(done), .rd_word(rd_word)
    );

    // The unit takes the key after the first key permutation; the bench forms it.
    function automatic logic [55:0] key_reduce(input logic [63:0] k);
        logic [55:0] y;
        for (int i = 0; i < 56; i++) y[55 - i] = k[64 - PC1_T[i]];
        return y;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // One clock of the port-level model, compared every cycle.
    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        if (ended) return;
        check({"R2 ", tag}, "done", {63'd0, done}, {63'd0, exp_done});
        check(tag, "rd_word", {32'd0, rd_word}, {32'd0, exp_word});
    endtask

    task automatic issue(input logic [1:0] kind, input logic [63:0] data,
                         input logic [3:0] rnd, input logic dec, input logic hi,
                         input string tag);
        op_valid   = 1'b1;
        op_kind    = kind;
        op_data    = data;
        op_round   = rnd;
        op_decrypt = dec;
        op_hi      = hi;
        exp_done   = 1'b1;
        if (kind == 2'b10) exp_word = hi ? exp_out[63:32] : exp_out[31:0];
        step(tag);
        op_valid = 1'b0;
        exp_done = 1'b0;
    endtask

    task automatic read_block(input logic [63:0] expv, input string tag);
        exp_out = expv;
        issue(2'b10, 64'h0, 4'd0, 1'b0, 1'b1, tag);
        issue(2'b10, 64'h0, 4'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic run_rounds(input logic dec, input string tag);
        for (int r = 0; r < 16; r++) issue(2'b11, 64'h0, 4'(r), dec, 1'b0, tag);
    endtask

    task automatic known_answer(input logic [63:0] key, input logic [63:0] pt,
                                input logic [63:0] ct);
        issue(2'b00, {8'h00, key_reduce(key)}, 4'd0, 1'b0, 1'b0, "R4");
        issue(2'b01, pt, 4'd0, 1'b0, 1'b0, "R5");
        run_rounds(1'b0, "R7");
        read_block(ct, "R6");
        read_block(ct, "R10");
        issue(2'b01, ct, 4'd0, 1'b0, 1'b0, "R5");
        run_rounds(1'b1, "R8");
        read_block(pt, "R8");
        issue(2'b01, pt, 4'd0, 1'b0, 1'b0, "R5");
        run_rounds(1'b0, "R9");
        read_block(ct, "R9");
    endtask

    initial begin
        rst        = 1'b1;
        op_valid   = 1'b0;
        op_kind    = 2'b00;
        op_data    = '0;
        op_round   = '0;
        op_decrypt = 1'b0;
        op_hi      = 1'b0;
        exp_done   = 1'b0;
        exp_word   = '0;
        exp_out    = '0;
        step("R1");
        step("R1");
        rst = 1'b0;
        step("R1");
        read_block(64'h0, "R1");

        issue(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0, 1'b0, "R5");
        read_block(64'hFFFF_FFFF_FFFF_FFFF, "R5");

        // Strobe low with a live-looking operation on the other inputs.
        op_kind = 2'b10;
        op_data = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 4; i++) begin
            op_hi   = i[0];
            op_kind = 2'(i);
            step("R3");
        end
        read_block(64'hFFFF_FFFF_FFFF_FFFF, "R3");

        known_answer(64'h1334_5779_9BBC_DFF1, 64'h0123_4567_89AB_CDEF, 64'h85E8_1354_0F0A_B405);
        known_answer(64'h0E32_9232_EA6D_0D73, 64'h8787_8787_8787_8787, 64'h0000_0000_0000_0000);
        known_answer(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h8CA6_4DE9_C1B1_23A7);
        known_answer(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7359_B216_3E4E_DC58);

        repeat (2) step("R3");
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule